// File: doc/BRIEF.md
# LED Blink Sequencer with Trigger Timer

The block drives one LED output with a 16-slot pulse-width pattern whose duty is set by a 4-bit brightness code. In its plain mode it runs a blink sequence: a lit phase at the programmed brightness, then a dark phase. Each phase length is counted in time units. The lit/dark pair is repeated a programmed number of times, or without end. When a finite sequence ends, the block can raise a one-cycle interrupt.

Two trigger modes reuse the same timing base. The block watches one of several input lines, picked by a select code. In one-shot mode, a rising edge on that line starts a pulse whose length is the programmed timeout. In watchdog mode, each edge restarts the timeout. If no edge comes before the timeout ends, the block emits a fixed short pulse. The timeout code scales roughly exponentially. All timing comes from a clock prescaler set by parameters. While the channel is disabled, or once a sequence has finished, the output rests at a programmable idle level.

Top module: `led_pwm_seq`

## Requirements
- R1: While the output shows the duty pattern, each frame is 16 ticks and starts high. Brightness code n holds the output high for the first n+1 ticks and low for the rest. A tick is TICK_DIV clock cycles, and slot counting restarts at each mode start.
- R2: In plain mode the lit phase lasts on_len_i+1 time units. One time unit is UNIT_FRAMES frames.
- R3: The dark phase lasts off_len_i time units with the output low. A value of 0 skips the dark phase.
- R4: reps_i values 1 to 3 run that many lit/dark cycles, after which the output rests at off_level_i. A value of 0 repeats forever.
- R5: irq_o pulses for exactly one cycle, and only if irq_en_i is set. Plain mode: in the first cycle after the last cycle ends. One-shot mode: in the first cycle after the pulse. Watchdog mode: in the first cycle of the fixed pulse.
- R6: While en_i is low (from the cycle after it falls) and during reset, pwm_o equals off_level_i and irq_o is 0.
- R7: Only a rising edge on trig_lines_i[trig_sel_i] acts; edges on the other lines have no effect. A line driven high before clock edge k is acted on at edge k+2, so the new state shows from the third cycle after the change.
- R8: Timeout code k lasts Q(k)·BASE_TICKS ticks. Q(k) = 2^k for k ≤ 10, and Q(k) = 2000·2^(k−11) for k ≥ 11.
- R9: One-shot mode (trig_en_i=1, wdog_i=0): a trigger edge starts a pulse that shows the duty pattern for the timeout length. Edges during the pulse are ignored.
- R10: Watchdog mode (trig_en_i=1, wdog_i=1): the timeout starts when the channel is enabled and restarts on each trigger edge. When it expires with no edge, pwm_o is driven to 1 for PULSE_TICKS ticks. Edges during that pulse are ignored.
- R11: With reload_i=1, a finished one-shot re-arms and a watchdog pulse restarts the timeout. With reload_i=0, the channel rests at off_level_i and ignores further triggers until it is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable |
| off_level_i | input | 1 | Output level while idle or finished |
| bright_i | input | 4 | Brightness code |
| on_len_i | input | 2 | Lit phase length minus one, in time units |
| off_len_i | input | 2 | Dark phase length, in time units |
| reps_i | input | 2 | Blink cycle count, 0 = endless |
| irq_en_i | input | 1 | Interrupt enable |
| trig_en_i | input | 1 | Selects trigger operation |
| wdog_i | input | 1 | 1 = watchdog, 0 = one-shot |
| reload_i | input | 1 | Re-arm after a pulse |
| trig_sel_i | input | $clog2(N_TRIG) | Trigger line select |
| trig_lines_i | input | N_TRIG | Trigger input lines |
| timeout_i | input | 4 | Timeout code |
| pwm_o | output | 1 | LED drive output |
| irq_o | output | 1 | Completion interrupt pulse |

## Verification
The properties assume that the mode, length, repeat and timeout inputs do not change while en_i is high. They also assume that a trigger line, once raised, stays at each level for at least one clock. The bench therefore changes configuration only while the channel is disabled, and starts each run by raising en_i at a known cycle. It drives trigger pulses one clock wide with gaps of several cycles, at points where the expected outcome is known. Expected waveforms are computed per cycle from the requirement formulas.

// File: rtl/led_seq_pkg.sv
package led_seq_pkg;

  localparam int SLOTS      = 16;
  localparam int TO_MAX_Q   = 32000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_ARMED,
    ST_SHOT,
    ST_WAIT,
    ST_FIRE,
    ST_DONE
  } seq_state_e;

  // base quanta per timeout code: doubling to 1024, then 2000 doubling
  function automatic logic [15:0] timeout_quanta(input logic [3:0] code);
    if (code <= 4'd10) return 16'd1 << code;
    else               return 16'd2000 << (code - 4'd11);
  endfunction

endpackage

// File: rtl/led_pwm_core.sv
module led_pwm_core #(
  parameter int TICK_DIV = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic [3:0] bright_i,
  output logic       tick_o,
  output logic [3:0] slot_o,
  output logic       duty_o,
  output logic       frame_end_o
);

  logic       tick_w;
  logic [3:0] slot_q;

  generate
    if (TICK_DIV <= 1) begin : g_nodiv
      assign tick_w = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(TICK_DIV);
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)               pre_q <= '0;
        else if (clr_i || tick_w)  pre_q <= '0;
        else                       pre_q <= pre_q + 1'b1;
      end
      assign tick_w = (pre_q == PW'(TICK_DIV - 1));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     slot_q <= '0;
    else if (clr_i)  slot_q <= '0;
    else if (tick_w) slot_q <= slot_q + 4'd1;
  end

  assign tick_o      = tick_w;
  assign slot_o      = slot_q;
  assign duty_o      = (slot_q <= bright_i);
  assign frame_end_o = tick_w && (slot_q == 4'hF);

endmodule

// File: rtl/led_blink_seq.sv
module led_blink_seq #(
  parameter int UNIT_FRAMES = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       frame_end_i,
  input  logic [1:0] on_len_i,
  input  logic [1:0] off_len_i,
  input  logic [1:0] reps_i,
  output logic       on_phase_o,
  output logic       done_o
);

  localparam int FW = $clog2(4 * UNIT_FRAMES + 1);
  localparam logic [FW-1:0] UNIT_W = FW'(UNIT_FRAMES);

  logic          dark_q;
  logic [FW-1:0] fc_q;
  logic [1:0]    rc_q;
  logic [FW-1:0] ph_len;
  logic          last_frame, cycle_end;

  always_comb begin
    if (dark_q) ph_len = FW'(off_len_i) * UNIT_W;
    else        ph_len = (FW'(on_len_i) + FW'(1)) * UNIT_W;
  end

  assign last_frame = frame_end_i && (fc_q == ph_len - FW'(1));
  assign cycle_end  = last_frame && (dark_q || off_len_i == 2'd0);
  assign done_o     = cycle_end && (reps_i != 2'd0) && (rc_q == reps_i - 2'd1);
  assign on_phase_o = !dark_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dark_q <= 1'b0;
      fc_q   <= '0;
      rc_q   <= '0;
    end else if (clr_i) begin
      dark_q <= 1'b0;
      fc_q   <= '0;
      rc_q   <= '0;
    end else if (last_frame) begin
      fc_q <= '0;
      if (cycle_end) begin
        dark_q <= 1'b0;
        rc_q   <= rc_q + 2'd1;
      end else begin
        dark_q <= 1'b1;
      end
    end else if (frame_end_i) begin
      fc_q <= fc_q + FW'(1);
    end
  end

endmodule

// File: rtl/led_trig_timer.sv
module led_trig_timer
  import led_seq_pkg::*;
#(
  parameter int N_TRIG      = 8,
  parameter int BASE_TICKS  = 50,
  parameter int PULSE_TICKS = 4,
  localparam int SW         = $clog2(N_TRIG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_TRIG-1:0] lines_i,
  input  logic [SW-1:0]     sel_i,
  input  logic              clr_i,
  input  logic              tick_i,
  input  logic              use_pulse_i,
  input  logic [3:0]        code_i,
  output logic              edge_o,
  output logic              elapsed_o
);

  localparam int TO_MAX = TO_MAX_Q * BASE_TICKS;
  localparam int T_MAX  = (PULSE_TICKS > TO_MAX) ? PULSE_TICKS : TO_MAX;
  localparam int TW     = $clog2(T_MAX + 1);
  localparam logic [TW-1:0] BASE_W  = TW'(BASE_TICKS);
  localparam logic [TW-1:0] PULSE_W = TW'(PULSE_TICKS);

  logic [N_TRIG-1:0] s1_q, s2_q;
  logic              prev_q;
  logic              sel_w;
  logic [TW-1:0]     cnt_q;
  logic [TW-1:0]     target_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= lines_i;
      s2_q   <= s1_q;
      prev_q <= sel_w;
    end
  end

  assign sel_w  = s2_q[sel_i];
  assign edge_o = sel_w && !prev_q;

  always_comb begin
    if (use_pulse_i) target_w = PULSE_W;
    else             target_w = TW'(timeout_quanta(code_i)) * BASE_W;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + TW'(1);
  end

  assign elapsed_o = tick_i && (cnt_q == target_w - TW'(1));

endmodule

// File: rtl/led_pwm_seq.sv
module led_pwm_seq
  import led_seq_pkg::*;
#(
  parameter int TICK_DIV    = 64,
  parameter int UNIT_FRAMES = 32,
  parameter int BASE_TICKS  = 50,
  parameter int PULSE_TICKS = 4,
  parameter int N_TRIG      = 8,
  localparam int SW         = $clog2(N_TRIG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              off_level_i,
  input  logic [3:0]        bright_i,
  input  logic [1:0]        on_len_i,
  input  logic [1:0]        off_len_i,
  input  logic [1:0]        reps_i,
  input  logic              irq_en_i,
  input  logic              trig_en_i,
  input  logic              wdog_i,
  input  logic              reload_i,
  input  logic [SW-1:0]     trig_sel_i,
  input  logic [N_TRIG-1:0] trig_lines_i,
  input  logic [3:0]        timeout_i,
  output logic              pwm_o,
  output logic              irq_o
);

  seq_state_e state_q, state_d;
  logic       clr_w, restart_w, irq_set_w, irq_q;
  logic       tick_w, duty_w, frame_end_w;
  logic [3:0] slot_w;
  logic       on_phase_w, seq_done_w;
  logic       trig_edge_w, elapsed_w;

  led_pwm_core #(.TICK_DIV(TICK_DIV)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr_w),
    .bright_i    (bright_i),
    .tick_o      (tick_w),
    .slot_o      (slot_w),
    .duty_o      (duty_w),
    .frame_end_o (frame_end_w)
  );

  led_blink_seq #(.UNIT_FRAMES(UNIT_FRAMES)) u_blink (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr_w),
    .frame_end_i (frame_end_w),
    .on_len_i    (on_len_i),
    .off_len_i   (off_len_i),
    .reps_i      (reps_i),
    .on_phase_o  (on_phase_w),
    .done_o      (seq_done_w)
  );

  led_trig_timer #(
    .N_TRIG      (N_TRIG),
    .BASE_TICKS  (BASE_TICKS),
    .PULSE_TICKS (PULSE_TICKS)
  ) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lines_i     (trig_lines_i),
    .sel_i       (trig_sel_i),
    .clr_i       (clr_w),
    .tick_i      (tick_w),
    .use_pulse_i (state_q == ST_FIRE),
    .code_i      (timeout_i),
    .edge_o      (trig_edge_w),
    .elapsed_o   (elapsed_w)
  );

  always_comb begin
    state_d   = state_q;
    irq_set_w = 1'b0;
    restart_w = 1'b0;
    if (!en_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (!trig_en_i)  state_d = ST_RUN;
          else if (wdog_i) state_d = ST_WAIT;
          else             state_d = ST_ARMED;
        end
        ST_RUN: begin
          if (seq_done_w) begin
            state_d   = ST_DONE;
            irq_set_w = 1'b1;
          end
        end
        ST_ARMED: if (trig_edge_w) state_d = ST_SHOT;
        ST_SHOT: begin
          if (elapsed_w) begin
            irq_set_w = 1'b1;
            state_d   = reload_i ? ST_ARMED : ST_DONE;
          end
        end
        ST_WAIT: begin
          if (elapsed_w) begin
            state_d   = ST_FIRE;
            irq_set_w = 1'b1;
          end else if (trig_edge_w) begin
            restart_w = 1'b1;
          end
        end
        ST_FIRE: if (elapsed_w) state_d = reload_i ? ST_WAIT : ST_DONE;
        ST_DONE: state_d = ST_DONE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  // counters restart on every state change and are held in waiting states
  assign clr_w = restart_w || (state_d != state_q) ||
                 (state_q inside {ST_IDLE, ST_ARMED, ST_DONE});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= irq_set_w && irq_en_i;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_RUN:  pwm_o = on_phase_w && duty_w;
      ST_SHOT: pwm_o = duty_w;
      ST_FIRE: pwm_o = 1'b1;
      default: pwm_o = off_level_i;
    endcase
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/led_pwm_seq_chk.sv
module led_pwm_seq_chk
  import led_seq_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       off_level_i,
  input logic       irq_en_i,
  input logic [3:0] bright_i,
  input logic       pwm_o,
  input logic       irq_o,
  input seq_state_e state_i,
  input logic [3:0] slot_i,
  input logic       on_phase_i
);

  p_idle_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!en_i) && !en_i) |-> (pwm_o == off_level_i));

  p_irq_gated_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(irq_en_i));

  p_irq_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_slot0_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_RUN && on_phase_i && slot_i == 4'd0) |-> pwm_o);

  p_dark_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_RUN && !on_phase_i) |-> !pwm_o);

  p_full_scale_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_SHOT && bright_i == 4'hF) |-> pwm_o);

  p_fire_high_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_FIRE) |-> pwm_o);

  p_done_level_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_DONE) |-> (pwm_o == off_level_i));

endmodule

bind led_pwm_seq led_pwm_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .off_level_i (off_level_i),
  .irq_en_i    (irq_en_i),
  .bright_i    (bright_i),
  .pwm_o       (pwm_o),
  .irq_o       (irq_o),
  .state_i     (state_q),
  .slot_i      (slot_w),
  .on_phase_i  (on_phase_w)
);

// File: tb/led_pwm_seq_tb.sv
module led_pwm_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int D   = 2;   // TICK_DIV
  localparam int UF  = 1;   // UNIT_FRAMES
  localparam int BT  = 1;   // BASE_TICKS
  localparam int PT  = 3;   // PULSE_TICKS
  localparam int FC  = 16 * D;
  localparam int UC  = UF * FC;
  localparam int WC  = PT * D;
  localparam int MAX_CYC = 190000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic       off_level_i = 1'b1;
  logic [3:0] bright_i = '0;
  logic [1:0] on_len_i = '0, off_len_i = '0, reps_i = '0;
  logic       irq_en_i = 1'b0, trig_en_i = 1'b0, wdog_i = 1'b0, reload_i = 1'b0;
  logic [2:0] trig_sel_i = '0;
  logic [7:0] trig_lines_i = '0;
  logic [3:0] timeout_i = '0;
  logic       pwm_o, irq_o;

  int n_checks = 0, n_fail = 0;
  bit finished = 1'b0;

  // scenario model
  int scen, g_L, g_fire;
  int kick0, kstep, kn;

  led_pwm_seq #(
    .TICK_DIV(D), .UNIT_FRAMES(UF), .BASE_TICKS(BT), .PULSE_TICKS(PT), .N_TRIG(8)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .off_level_i(off_level_i),
    .bright_i(bright_i), .on_len_i(on_len_i), .off_len_i(off_len_i),
    .reps_i(reps_i), .irq_en_i(irq_en_i), .trig_en_i(trig_en_i),
    .wdog_i(wdog_i), .reload_i(reload_i), .trig_sel_i(trig_sel_i),
    .trig_lines_i(trig_lines_i), .timeout_i(timeout_i),
    .pwm_o(pwm_o), .irq_o(irq_o)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  function automatic int q_of(int k);
    return (k <= 10) ? (1 << k) : 2000 * (1 << (k - 11));
  endfunction

  function automatic bit duty_at(int pos);
    return ((pos % FC) / D) <= int'(bright_i);
  endfunction

  function automatic bit exp_pwm(int t);
    int cyc, p;
    case (scen)
      0: begin
        cyc = (int'(on_len_i) + 1 + int'(off_len_i)) * UC;
        if (reps_i != 0 && t >= int'(reps_i) * cyc) return off_level_i;
        p = t % cyc;
        if (p >= (int'(on_len_i) + 1) * UC) return 1'b0;
        return duty_at(p);
      end
      1: return (t >= 2 && t < 2 + g_L) ? duty_at(t - 2) : off_level_i;
      2: begin
        p = g_L + WC;
        if (!reload_i && t >= p) return off_level_i;
        return ((t % p) >= g_L) ? 1'b1 : off_level_i;
      end
      4: return (t >= g_fire && t < g_fire + WC) ? 1'b1 : off_level_i;
      default: return off_level_i;
    endcase
  endfunction

  function automatic bit exp_irq(int t);
    int cyc, p;
    if (!irq_en_i) return 1'b0;
    case (scen)
      0: begin
        cyc = (int'(on_len_i) + 1 + int'(off_len_i)) * UC;
        return reps_i != 0 && t == int'(reps_i) * cyc;
      end
      1: return t == 2 + g_L;
      2: begin
        p = g_L + WC;
        return ((t % p) == g_L) && (reload_i || t < p);
      end
      4: return t == g_fire;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check1(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // window starts at a negedge; t counts subsequent negedge samples
  task automatic run_window(input int len, input string req);
    int bad = 0, bt = -1, ap = 0, ep = 0, ai = 0, ei = 0;
    for (int t = 0; t < len; t++) begin
      @(negedge clk);
      if (pwm_o !== exp_pwm(t) || irq_o !== exp_irq(t)) begin
        if (bad == 0) begin
          bt = t; ap = int'(pwm_o); ep = int'(exp_pwm(t)); ai = int'(irq_o); ei = int'(exp_irq(t));
        end
        bad++;
      end
      if (kn > 0 && t >= kick0 && ((t - kick0) % kstep) == 0 && ((t - kick0) / kstep) < kn)
        trig_lines_i = 8'd1 << trig_sel_i;
      else
        trig_lines_i = '0;
    end
    n_checks++;
    if (bad != 0) begin
      n_fail++;
      $display("FAIL %s: cycle %0d actual pwm=%0d irq=%0d expected pwm=%0d irq=%0d",
               req, bt, ap, ai, ep, ei);
    end
  endtask

  task automatic disable_ch();
    @(negedge clk);
    en_i = 1'b0;
    trig_lines_i = '0;
    @(negedge clk);
  endtask

  initial begin
    kn = 0; kick0 = 0; kstep = 1; scen = 3; g_L = 0; g_fire = 0;
    // reset state: R6
    repeat (3) @(negedge clk);
    check1(pwm_o === 1'b1, "R6 reset level", int'(pwm_o), 1);
    check1(irq_o === 1'b0, "R6 reset irq", int'(irq_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1: brightness sweep, single short blink
    scen = 0;
    for (int b = 0; b < 16; b++) begin
      bright_i = 4'(b); on_len_i = 0; off_len_i = 0; reps_i = 1;
      irq_en_i = 1'b1; off_level_i = 1'(b & 1);
      en_i = 1'b1;
      run_window(UC + 4, $sformatf("R1 duty code %0d", b));
      disable_ch();
    end

    // R2 R3 R4 R5: phase lengths and repetitions
    for (int on = 0; on < 4; on++)
      for (int off = 0; off < 4; off++)
        for (int r = 1; r < 4; r++) begin
          bright_i = 4'((on * 4 + off + r) % 16);
          on_len_i = 2'(on); off_len_i = 2'(off); reps_i = 2'(r);
          irq_en_i = 1'((on + off + r) & 1); off_level_i = 1'(off & 1);
          en_i = 1'b1;
          run_window(r * (on + 1 + off) * UC + 4,
                     $sformatf("R2/R3/R4/R5 on=%0d off=%0d reps=%0d", on, off, r));
          disable_ch();
        end

    // R4: endless repetition, no irq
    bright_i = 4'd5; on_len_i = 1; off_len_i = 1; reps_i = 0; irq_en_i = 1'b1; off_level_i = 1'b1;
    en_i = 1'b1;
    run_window(5 * 3 * UC + 7, "R4 endless");

    // R6: disable mid-sequence, then change idle level while disabled
    @(negedge clk);
    en_i = 1'b0;
    @(negedge clk);
    check1(pwm_o === 1'b1, "R6 disable level high", int'(pwm_o), 1);
    off_level_i = 1'b0;
    #1;
    check1(pwm_o === 1'b0, "R6 disable level low", int'(pwm_o), 0);
    @(negedge clk);

    // R7 R8 R9 R11: one-shot across timeout codes, reload on
    trig_en_i = 1'b1; wdog_i = 1'b0; reload_i = 1'b1; irq_en_i = 1'b1;
    for (int k = 0; k <= 12; k++) begin
      scen = 1;
      timeout_i = 4'(k); trig_sel_i = 3'(k % 8);
      bright_i = (k == 12) ? 4'hF : 4'(k); off_level_i = 1'(k & 1);
      g_L = q_of(k) * BT * D;
      en_i = 1'b1;
      repeat (3) @(negedge clk);
      trig_lines_i = 8'd1 << trig_sel_i;
      kn = (g_L > 8) ? 1 : 0; kick0 = 4; kstep = 1;
      run_window(2 + g_L + 4, $sformatf("R7/R8/R9 one-shot code %0d", k));
      kn = 0;
      // re-armed: a second trigger fires again (R11)
      trig_lines_i = 8'd1 << trig_sel_i;
      run_window(2 + g_L + 3, $sformatf("R11 one-shot rearm code %0d", k));
      disable_ch();
    end

    // R7: edge on an unselected line does nothing
    scen = 3; timeout_i = 4'd2; trig_sel_i = 3'd5; off_level_i = 1'b0; bright_i = 4'hF;
    en_i = 1'b1;
    repeat (3) @(negedge clk);
    trig_lines_i = 8'b0100_0000;
    run_window(30, "R7 wrong line ignored");
    disable_ch();

    // R11: reload off, a second trigger is ignored
    reload_i = 1'b0; scen = 1; g_L = q_of(2) * BT * D; trig_sel_i = 3'd3; bright_i = 4'd9;
    en_i = 1'b1;
    repeat (3) @(negedge clk);
    trig_lines_i = 8'd1 << trig_sel_i;
    run_window(2 + g_L + 4, "R9 one-shot no reload");
    scen = 3;
    trig_lines_i = 8'd1 << trig_sel_i;
    run_window(40, "R11 one-shot no reload ignores trigger");
    disable_ch();

    // R10 R8 R5: watchdog free run with reload
    wdog_i = 1'b1; reload_i = 1'b1; irq_en_i = 1'b1; off_level_i = 1'b0;
    for (int k = 0; k <= 6; k++) begin
      scen = 2; timeout_i = 4'(k); g_L = q_of(k) * BT * D;
      irq_en_i = 1'(k != 3);
      en_i = 1'b1;
      run_window(2 * (g_L + WC) + 3, $sformatf("R10/R8 watchdog code %0d", k));
      disable_ch();
    end

    // R11: watchdog without reload stays idle after one pulse
    reload_i = 1'b0; scen = 2; timeout_i = 4'd2; g_L = q_of(2) * BT * D; irq_en_i = 1'b1;
    en_i = 1'b1;
    run_window(4 * (g_L + WC), "R11 watchdog no reload");
    disable_ch();

    // R10: trigger edges keep the watchdog from firing
    reload_i = 1'b1; scen = 4; timeout_i = 4'd3; trig_sel_i = 3'd6;
    g_L = q_of(3) * BT * D;
    kn = 4; kick0 = 5; kstep = 10;
    g_fire = kick0 + 3 * kstep + 3 + g_L;
    en_i = 1'b1;
    run_window(g_fire + WC + 3, "R10 watchdog restarted by triggers");
    kn = 0;
    disable_ch();

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule